// File: doc/BRIEF.md
# Memory Block Move and Scan Sequencer

This block walks through memory one byte per iteration under the control of three 16-bit registers: a source pointer, a destination pointer and a remaining-count. In move mode it reads the byte at the source pointer and stores it at the destination pointer. In scan mode it reads the byte at the source pointer and subtracts it from an 8-bit reference value to produce condition flags, and it never writes. In both modes each iteration steps the pointers by one, either upward or downward, and lowers the count by one.

A one-step operation runs a single iteration. A looping operation keeps going until the count runs out or, in scan mode, until the byte read equals the reference value. A caller loads the pointers, count, reference value and incoming flags together with a start pulse. The block then drives a synchronous single-port memory. When it finishes it raises `done` for one cycle and presents the final pointers, count, flags and match result. Fetching, decoding and interrupt handling belong to the surrounding processor.

Top module: `blockSeqEngine`

## Requirements
- R1: In move mode (`opMode[0]`=0) each iteration reads the byte at `srcOut` during its first cycle (`memAddr`=source pointer). In its second cycle it writes that byte to the destination pointer, with `memWe` high for exactly that one cycle.
- R2: `opMode[1]`=0 adds 1 to the pointers after each iteration and `opMode[1]`=1 subtracts 1. In move mode both pointers step; in scan mode only the source pointer steps. All pointers wrap modulo 2^16 (0xFFFF+1=0x0000, 0x0000-1=0xFFFF).
- R3: Every iteration lowers the count by one modulo 2^16. A starting count of 0 therefore behaves as 65536 and leaves 0xFFFF after one iteration.
- R4: Scan mode (`opMode[0]`=1) never asserts `memWe`. `matchOut` is cleared at start and shows afterwards whether the last byte read equalled the reference value.
- R5: A looping move (`repeatEn`=1) keeps iterating until the count reaches zero.
- R6: A looping scan stops after the first iteration whose byte equals the reference value, or after the iteration that brings the count to zero, whichever comes first.
- R7: Move flags (bit 7 sign, bit 6 zero, bit 4 half-carry, bit 2 parity/overflow, bit 1 subtract, bit 0 carry): half-carry and subtract become 0, sign, zero and carry keep their loaded values, and parity/overflow is 1 exactly when the count after the iteration is nonzero. Bits 5 and 3 always keep their loaded values.
- R8: Scan flags: sign is bit 7 of (reference − byte), zero is 1 when they are equal, half-carry is 1 when the low nibble of the reference is below the low nibble of the byte, subtract is 1, carry keeps its value, and parity/overflow follows the R7 rule.
- R9: `start` is taken on a rising edge while `busy` is low, and `busy` is high from the next cycle. Each iteration takes exactly two cycles. `done` is a one-cycle pulse that appears 2·N cycles after the start edge for N iterations, and `busy` is low while `done` is high.
- R10: `start` while `busy` is high is ignored: the running operation ends with the results it would have produced anyway.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation using the loaded values |
| opMode | input | 2 | Bit 0: 0 move, 1 scan; bit 1: 0 ascend, 1 descend |
| repeatEn | input | 1 | 1 loops until termination, 0 runs one iteration |
| srcIn | input | 16 | Initial source pointer |
| dstIn | input | 16 | Initial destination pointer |
| cntIn | input | 16 | Initial count (0 means 65536) |
| accIn | input | 8 | Reference value for scans |
| flagsIn | input | 8 | Flag byte before the operation |
| memRdata | input | 8 | Read data, valid one cycle after its address |
| memAddr | output | 16 | Memory address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| matchOut | output | 1 | Last scanned byte equalled the reference |
| srcOut | output | 16 | Current source pointer |
| dstOut | output | 16 | Current destination pointer |
| cntOut | output | 16 | Current count |
| flagsOut | output | 8 | Current flag byte |

## Verification
`busy` must be high one cycle after the start edge. For an operation of N iterations, `done` must appear exactly 2·N cycles after that edge. Pointers, count, flags and match are final in that same cycle. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start edge until `done` and compares the count with twice the iteration count of its own reference walk. It reads every result in the `done` cycle, compares the whole memory image afterwards, and checks on the next falling edge that `done` has dropped.

// File: rtl/blockSeqPkg.sv
package blockSeqPkg;

  // Flag byte bit positions (processor status layout)
  localparam int FLAG_C  = 0;
  localparam int FLAG_N  = 1;
  localparam int FLAG_PV = 2;
  localparam int FLAG_H  = 4;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_S  = 7;
  localparam int FLAG_W  = 8;

  // opMode bit meanings
  localparam int MODE_CMP_BIT = 0;
  localparam int MODE_DEC_BIT = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EXEC = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture operands at start
    logic rdPhase;  // present source address to memory
    logic step;     // consume read data, update state
  } pathCtl_t;

endpackage

// File: rtl/blockSeqAddrStep.sv
module blockSeqAddrStep #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addrIn,
  input  logic          decEn,
  output logic [AW-1:0] addrOut
);
  localparam logic [AW-1:0] UNIT = AW'(1);

  // Modulo 2^AW step in either direction
  assign addrOut = decEn ? (addrIn - UNIT) : (addrIn + UNIT);
endmodule

// File: rtl/blockSeqPath.sv
module blockSeqPath
  import blockSeqPkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [1:0]        opMode,
  input  logic              repeatEn,
  input  logic [AW-1:0]     srcIn,
  input  logic [AW-1:0]     dstIn,
  input  logic [AW-1:0]     cntIn,
  input  logic [DW-1:0]     accIn,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [DW-1:0]     memRdata,
  output logic [AW-1:0]     memAddr,
  output logic [DW-1:0]     memWdata,
  output logic              memWe,
  output logic              lastStep,
  output logic              repOut,
  output logic              matchOut,
  output logic [AW-1:0]     srcOut,
  output logic [AW-1:0]     dstOut,
  output logic [AW-1:0]     cntOut,
  output logic [FLAG_W-1:0] flagsOut
);
  localparam int NW = DW / 2;
  localparam logic [AW-1:0] UNIT = AW'(1);

  logic [AW-1:0]     srcQ, dstQ, cntQ;
  logic [DW-1:0]     accQ;
  logic [FLAG_W-1:0] flagsQ;
  logic              matchQ, cmpQ, decQ, repQ;

  logic [AW-1:0]     srcNext, dstNext, cntNext;
  logic [DW-1:0]     diff;
  logic              equalNow, halfBorrow, cntLeft;
  logic [FLAG_W-1:0] flagsNext;

  blockSeqAddrStep #(.AW(AW)) uSrcStep (
    .addrIn (srcQ),
    .decEn  (decQ),
    .addrOut(srcNext)
  );

  blockSeqAddrStep #(.AW(AW)) uDstStep (
    .addrIn (dstQ),
    .decEn  (decQ),
    .addrOut(dstNext)
  );

  assign cntNext    = cntQ - UNIT;
  assign cntLeft    = |cntNext;
  assign diff       = accQ - memRdata;
  assign equalNow   = (accQ == memRdata);
  assign halfBorrow = (accQ[NW-1:0] < memRdata[NW-1:0]);

  // Termination: count exhausted, or a scan hit
  assign lastStep = !cntLeft || (cmpQ && equalNow);

  always_comb begin
    flagsNext          = flagsQ;
    flagsNext[FLAG_PV] = cntLeft;
    if (cmpQ) begin
      flagsNext[FLAG_S] = diff[DW-1];
      flagsNext[FLAG_Z] = equalNow;
      flagsNext[FLAG_H] = halfBorrow;
      flagsNext[FLAG_N] = 1'b1;
    end else begin
      flagsNext[FLAG_H] = 1'b0;
      flagsNext[FLAG_N] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ   <= '0;
      dstQ   <= '0;
      cntQ   <= '0;
      accQ   <= '0;
      flagsQ <= '0;
      matchQ <= 1'b0;
      cmpQ   <= 1'b0;
      decQ   <= 1'b0;
      repQ   <= 1'b0;
    end else if (ctl.load) begin
      srcQ   <= srcIn;
      dstQ   <= dstIn;
      cntQ   <= cntIn;
      accQ   <= accIn;
      flagsQ <= flagsIn;
      matchQ <= 1'b0;
      cmpQ   <= opMode[MODE_CMP_BIT];
      decQ   <= opMode[MODE_DEC_BIT];
      repQ   <= repeatEn;
    end else if (ctl.step) begin
      srcQ   <= srcNext;
      if (!cmpQ) dstQ <= dstNext;
      cntQ   <= cntNext;
      flagsQ <= flagsNext;
      matchQ <= cmpQ && equalNow;
    end
  end

  // Read cycle addresses the source, execute cycle the destination
  assign memAddr  = ctl.rdPhase ? srcQ : dstQ;
  assign memWdata = memRdata;
  assign memWe    = ctl.step && !cmpQ;

  assign repOut   = repQ;
  assign matchOut = matchQ;
  assign srcOut   = srcQ;
  assign dstOut   = dstQ;
  assign cntOut   = cntQ;
  assign flagsOut = flagsQ;

  // R2: ascending source step
  a_r2_src_ascend: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !decQ) |=> (srcQ == $past(srcQ) + UNIT));

  // R2: descending source step
  a_r2_src_descend: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && decQ) |=> (srcQ == $past(srcQ) - UNIT));

  // R3: count drops by one per iteration
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> (cntQ == $past(cntQ) - UNIT));

  // R4: scans never write memory
  a_r4_scan_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (cmpQ && !ctl.load) |-> !memWe);

  // R7: move flag rules
  a_r7_move_flags: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !cmpQ) |=> (!flagsQ[FLAG_H] && !flagsQ[FLAG_N]
                             && flagsQ[FLAG_S] == $past(flagsQ[FLAG_S])
                             && flagsQ[FLAG_C] == $past(flagsQ[FLAG_C])));

  // R8: scan flag rules
  a_r8_scan_flags: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && cmpQ) |=> (flagsQ[FLAG_N]
                            && flagsQ[FLAG_C] == $past(flagsQ[FLAG_C])
                            && flagsQ[FLAG_Z] == matchQ));
endmodule

// File: rtl/blockSeqCtrl.sv
module blockSeqCtrl
  import blockSeqPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     lastStep,
  input  logic     repIn,
  output pathCtl_t ctl,
  output logic     busy,
  output logic     done
);
  seqState_t stateQ, stateNext;
  logic      doneQ, finishNow;

  assign finishNow = (stateQ == ST_EXEC) && (lastStep || !repIn);

  always_comb begin
    ctl       = '0;
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        ctl.load = start;
        if (start) stateNext = ST_READ;
      end
      ST_READ: begin
        ctl.rdPhase = 1'b1;
        stateNext   = ST_EXEC;
      end
      ST_EXEC: begin
        ctl.step  = 1'b1;
        stateNext = finishNow ? ST_IDLE : ST_READ;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateNext;
      doneQ  <= finishNow;
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

  // R9: an iteration is a read cycle followed by an execute cycle
  a_r9_read_then_exec: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_READ) |=> (stateQ == ST_EXEC));

  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R5: an unfinished looping operation starts another read
  a_r5_loop_continues: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_EXEC && repIn && !lastStep) |=> (stateQ == ST_READ));
endmodule

// File: rtl/blockSeqEngine.sv
module blockSeqEngine
  import blockSeqPkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [1:0]    opMode,
  input  logic          repeatEn,
  input  logic [AW-1:0] srcIn,
  input  logic [AW-1:0] dstIn,
  input  logic [AW-1:0] cntIn,
  input  logic [DW-1:0] accIn,
  input  logic [7:0]    flagsIn,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memWe,
  output logic          busy,
  output logic          done,
  output logic          matchOut,
  output logic [AW-1:0] srcOut,
  output logic [AW-1:0] dstOut,
  output logic [AW-1:0] cntOut,
  output logic [7:0]    flagsOut
);
  pathCtl_t ctl;
  logic     lastStep, repQ;

  blockSeqCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .lastStep(lastStep),
    .repIn   (repQ),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done)
  );

  blockSeqPath #(.AW(AW), .DW(DW)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .opMode  (opMode),
    .repeatEn(repeatEn),
    .srcIn   (srcIn),
    .dstIn   (dstIn),
    .cntIn   (cntIn),
    .accIn   (accIn),
    .flagsIn (flagsIn),
    .memRdata(memRdata),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .memWe   (memWe),
    .lastStep(lastStep),
    .repOut  (repQ),
    .matchOut(matchOut),
    .srcOut  (srcOut),
    .dstOut  (dstOut),
    .cntOut  (cntOut),
    .flagsOut(flagsOut)
  );

  // R10: a start during an operation leaves the captured operation alone
  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable({uPath.cmpQ, uPath.decQ, uPath.repQ, uPath.accQ}));

  // R9: done only when the engine has gone idle
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

// File: tb/blockSeqEngine_test.sv
module blockSeqEngine_test;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BITS   = 12;
  localparam int MEM_SIZE   = 1 << MEM_BITS;
  localparam int WATCHDOG   = 150000;

  localparam logic [1:0] MOVE_UP   = 2'b00;
  localparam logic [1:0] SCAN_UP   = 2'b01;
  localparam logic [1:0] MOVE_DOWN = 2'b10;
  localparam logic [1:0] SCAN_DOWN = 2'b11;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opMode = '0;
  logic        repeatEn = 1'b0;
  logic [15:0] srcIn = '0, dstIn = '0, cntIn = '0;
  logic [7:0]  accIn = '0, flagsIn = '0;
  logic [7:0]  memRdata;
  logic [15:0] memAddr;
  logic [7:0]  memWdata;
  logic        memWe, busy, done, matchOut;
  logic [15:0] srcOut, dstOut, cntOut;
  logic [7:0]  flagsOut;

  logic [7:0] mem    [MEM_SIZE];
  logic [7:0] refMem [MEM_SIZE];

  int checks = 0;
  int fails  = 0;
  int cycleCount = 0;

  blockSeqEngine uut (
    .clk(clk), .rstN(rstN), .start(start), .opMode(opMode), .repeatEn(repeatEn),
    .srcIn(srcIn), .dstIn(dstIn), .cntIn(cntIn), .accIn(accIn), .flagsIn(flagsIn),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .busy(busy), .done(done), .matchOut(matchOut), .srcOut(srcOut),
    .dstOut(dstOut), .cntOut(cntOut), .flagsOut(flagsOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Synchronous memory, read data one cycle after its address
  always @(posedge clk) begin
    if (memWe) mem[memAddr[MEM_BITS-1:0]] <= memWdata;
    memRdata <= mem[memAddr[MEM_BITS-1:0]];
  end

  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycleCount, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic fillMem(input int seed);
    for (int i = 0; i < MEM_SIZE; i++) begin
      mem[i]    = 8'(i * seed + (i >> 3) + 1);
      refMem[i] = mem[i];
    end
  endtask

  task automatic putByte(input int addr, input logic [7:0] val);
    mem[addr]    = val;
    refMem[addr] = val;
  endtask

  // Independent reference walk from the requirements
  task automatic refRun(input logic cmp, input logic dec, input logic rep,
                        input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                        input logic [7:0] a, input logic [7:0] f,
                        output logic [15:0] os, output logic [15:0] od,
                        output logic [15:0] oc, output logic [7:0] ofl,
                        output logic om, output int it);
    logic [7:0] b, r;
    logic term;
    os = s; od = d; oc = c; ofl = f; om = 1'b0; it = 0;
    do begin
      b = refMem[os[MEM_BITS-1:0]];
      if (!cmp) refMem[od[MEM_BITS-1:0]] = b;
      oc = oc - 16'd1;
      it++;
      ofl[2] = (oc != 16'd0);
      if (cmp) begin
        r = a - b;
        ofl[7] = r[7];
        ofl[6] = (a == b);
        ofl[4] = (a[3:0] < b[3:0]);
        ofl[1] = 1'b1;
        om = (a == b);
      end else begin
        ofl[4] = 1'b0;
        ofl[1] = 1'b0;
      end
      os = dec ? os - 16'd1 : os + 16'd1;
      if (!cmp) od = dec ? od - 16'd1 : od + 16'd1;
      term = (oc == 16'd0) || (cmp && a == b);
    end while (rep && !term);
  endtask

  task automatic runCase(input string req, input logic [1:0] mode, input logic rep,
                         input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                         input logic [7:0] a, input logic [7:0] f, input logic poke);
    logic [15:0] es, ed, ec;
    logic [7:0]  ef;
    logic        em;
    int          it, cyc, bad;
    refRun(mode[0], mode[1], rep, s, d, c, a, f, es, ed, ec, ef, em, it);
    @(negedge clk);
    opMode = mode; repeatEn = rep; srcIn = s; dstIn = d; cntIn = c;
    accIn = a; flagsIn = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "busy after start", 32'(busy), 32'd1);
    cyc = 0;
    if (poke) begin
      // R10: conflicting start in the middle of the operation
      start = 1'b1; opMode = ~mode; repeatEn = ~rep; srcIn = ~s;
      cntIn = 16'h0003; accIn = ~a; flagsIn = ~f;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
    end
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
    end
    chk(req, "cycles to done (R9)", 32'(cyc), 32'(2 * it));
    chk("R9", "busy low at done", 32'(busy), 32'd0);
    chk(req, "source pointer", 32'(srcOut), 32'(es));
    chk(req, "destination pointer", 32'(dstOut), 32'(ed));
    chk(req, "count", 32'(cntOut), 32'(ec));
    chk(req, "flags", 32'(flagsOut), 32'(ef));
    chk(req, "match", 32'(matchOut), 32'(em));
    @(negedge clk);
    chk("R9", "done is one cycle", 32'(done), 32'd0);
    bad = 0;
    for (int i = 0; i < MEM_SIZE; i++) if (mem[i] !== refMem[i]) bad++;
    chk(req, "memory mismatches (R1/R4)", 32'(bad), 32'd0);
  endtask

  task automatic testReset();
    chk("R9", "reset busy", 32'(busy), 32'd0);
    chk("R9", "reset done", 32'(done), 32'd0);
    chk("R1", "reset write enable", 32'(memWe), 32'd0);
    chk("R4", "reset match", 32'(matchOut), 32'd0);
  endtask

  task automatic testMoveSingle();
    runCase("R1_R7", MOVE_UP, 1'b0, 16'h0100, 16'h0300, 16'd5, 8'h00, 8'hFF, 1'b0);
  endtask

  task automatic testMoveLoopUp();
    runCase("R5", MOVE_UP, 1'b1, 16'h0040, 16'h0500, 16'd8, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic testMoveLoopDown();
    runCase("R2", MOVE_DOWN, 1'b1, 16'h07F0, 16'h07F3, 16'd6, 8'h00, 8'hC5, 1'b0);
  endtask

  task automatic testScanSingle();
    runCase("R4_R8", SCAN_UP, 1'b0, 16'h0200, 16'h0AAA, 16'd9,
            refMem[16'h0200] + 8'd1, 8'h01, 1'b0);
  endtask

  task automatic testScanHit();
    for (int i = 0; i < 4; i++) putByte(16'h0600 + i, 8'h11 + 8'(i));
    putByte(16'h0604, 8'hA5);
    runCase("R6", SCAN_UP, 1'b1, 16'h0600, 16'h0000, 16'd20, 8'hA5, 8'h28, 1'b0);
  endtask

  task automatic testScanExhaust();
    for (int i = 0; i < 8; i++) putByte(16'h0903 + i, 8'h3F - 8'(i));
    runCase("R6", SCAN_DOWN, 1'b1, 16'h090A, 16'h0123, 16'd7, 8'h20, 8'h00, 1'b0);
  endtask

  task automatic testHalfBorrow();
    putByte(16'h0222, 8'h1F);
    runCase("R8", SCAN_DOWN, 1'b0, 16'h0222, 16'h0000, 16'd2, 8'h20, 8'h80, 1'b0);
  endtask

  task automatic testZeroCount();
    runCase("R3", MOVE_UP, 1'b0, 16'h0310, 16'h0410, 16'h0000, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic testWrap();
    runCase("R2", MOVE_UP, 1'b0, 16'hFFFF, 16'h0FFF, 16'd4, 8'h00, 8'h00, 1'b0);
    runCase("R2", MOVE_DOWN, 1'b0, 16'h0000, 16'h0000, 16'd4, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic testBusyStart();
    runCase("R10", MOVE_UP, 1'b1, 16'h0700, 16'h0800, 16'd3, 8'h55, 8'h00, 1'b1);
  endtask

  initial begin
    fillMem(7);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testMoveSingle();
    testMoveLoopUp();
    testMoveLoopDown();
    testScanSingle();
    testScanHit();
    testScanExhaust();
    testHalfBorrow();
    testZeroCount();
    testWrap();
    testBusyStart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule